// File: doc/BRIEF.md
# Three-Master Fixed-Priority Bus Arbiter

This block decides which of three bus masters may drive a shared bus. Each master has a request line, a release line and a grant line. On every clock edge the requests are copied into a register. A combinational priority network then looks at that registered copy and picks at most one winner. The network only picks while the bus is idle. The winner's grant is held in a JK-style flop built from a D flop. Once set, a grant stays high until the owning master pulses its release line. A higher-priority request cannot take the bus away from the current owner.

The control is a two-state machine. In `ST_IDLE` no grant is held and the priority network is enabled. The transition `IDLE_TO_OWNED` fires when the network picks a winner, which is the same edge that sets the grant flop. In `ST_OWNED` the network is disabled. The transition `OWNED_TO_IDLE` fires on the edge where the owner's release is sampled, which is also the edge that clears its grant. Any master whose request is still registered can then win on the following edge.

Bit positions are fixed on every vector port: bit 0 is master A, bit 1 is master B and bit 2 is master C. The priority order is A first, then C, then B.

Top module: `busarb_central`

## Requirements
- R1: While `rst_n` is low, `gnt_o` is 3'b000, including when a grant was held before reset was asserted.
- R2: A request that is high at clock edge k, from an idle arbiter, shows on its `gnt_o` bit after edge k+1 and not after edge k. The grant does not depend on `req_i` at edge k+1.
- R3: When several masters are registered as requesting while idle, the grant goes to A (bit 0) first, then C (bit 2), then B (bit 1).
- R4: At most one bit of `gnt_o` is high in any cycle.
- R5: While a grant is held, requests from other masters, including higher-priority ones, do not change `gnt_o`.
- R6: A held grant stays high after its master drops its request, until that master releases it.
- R7: A high `rel_i` bit of the owning master clears `gnt_o` at the edge where it is sampled.
- R8: After a release edge, a master whose request was sampled at that release edge is granted on the next edge. This includes the master that just released, if it is still requesting.
- R9: A `rel_i` bit of a master that does not own the bus has no effect on `gnt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 3 | Bus requests; bit 0 = A, bit 1 = B, bit 2 = C |
| rel_i | input | 3 | Release pulses; a master drives its bit when it has finished with the bus |
| gnt_o | output | 3 | Grants, at most one high; same bit order as `req_i` |

## Verification
The assertions check on every cycle that there is never more than one grant. They also check that a held grant keeps its value until its owner releases it, and that an owner's release empties `gnt_o` on the next edge. For every newly set grant, they check that it goes to the highest-priority master among the requests sampled two edges earlier, and that an idle arbiter with a registered request always grants on the next edge. Some behaviours can only be shown by the directed scenarios: the exact two-edge latency, a grant staying high after its request is withdrawn, a release from a non-owner having no effect, reset clearing a live grant, and the full A, C, B hand-over sequence.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    localparam int ARB_N  = 3;
    localparam int ARB_IW = $clog2(ARB_N);

    // Priority slots, slot 0 = highest. Each slot holds a master index.
    // Order: A(0), then C(2), then B(1).
    localparam logic [ARB_N*ARB_IW-1:0] ARB_ORDER = {2'd1, 2'd2, 2'd0};

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OWNED = 1'b1
    } arb_state_t;

endpackage

// File: rtl/busarb_req_reg.sv
module busarb_req_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] req_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_i;
        end
    end

endmodule

// File: rtl/busarb_prio_net.sv
module busarb_prio_net #(
    parameter int                N     = 3,
    parameter int                IW    = 2,
    parameter logic [N*IW-1:0]   ORDER = {2'd1, 2'd2, 2'd0}
) (
    input  logic         en_i,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] pick_o
);

    // Walk slots from lowest priority to highest so the highest one wins.
    always_comb begin
        pick_o = '0;
        if (en_i) begin
            for (int s = N - 1; s >= 0; s--) begin
                if (req_i[ORDER[s*IW +: IW]]) begin
                    pick_o = '0;
                    pick_o[ORDER[s*IW +: IW]] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/busarb_jk_cell.sv
module busarb_jk_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic j_i,
    input  logic k_i,
    output logic q_o
);

    logic d;

    // hold on 00, clear on 01, set on 10, toggle on 11
    always_comb begin
        d = (j_i & ~q_o) | (~k_i & q_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else begin
            q_o <= d;
        end
    end

endmodule

// File: rtl/busarb_central.sv
module busarb_central
    import busarb_pkg::*;
#(
    parameter int                N     = ARB_N,
    parameter int                IW    = ARB_IW,
    parameter logic [N*IW-1:0]   ORDER = ARB_ORDER
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] rel_i,
    output logic [N-1:0] gnt_o
);

    arb_state_t   st_q;
    arb_state_t   st_nxt;
    logic         net_en;
    logic [N-1:0] req_q;
    logic [N-1:0] pick;
    logic [N-1:0] gnt;

    busarb_req_reg #(.N(N)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .req_q (req_q)
    );

    busarb_prio_net #(.N(N), .IW(IW), .ORDER(ORDER)) u_prio (
        .en_i   (net_en),
        .req_i  (req_q),
        .pick_o (pick)
    );

    for (genvar g = 0; g < N; g++) begin : g_hold
        busarb_jk_cell u_jk (
            .clk   (clk),
            .rst_n (rst_n),
            .j_i   (pick[g]),
            .k_i   (rel_i[g]),
            .q_o   (gnt[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (|pick) begin
                    st_nxt = ST_OWNED;          // IDLE_TO_OWNED
                end
            end
            ST_OWNED: begin
                if (|(gnt & rel_i)) begin
                    st_nxt = ST_IDLE;           // OWNED_TO_IDLE
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        net_en = (st_q == ST_IDLE);
        gnt_o  = gnt;
    end

endmodule

// File: rtl/busarb_central_chk.sv
module busarb_central_chk #(
    parameter int              N     = 3,
    parameter int              IW    = 2,
    parameter logic [N*IW-1:0] ORDER = {2'd1, 2'd2, 2'd0}
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_i,
    input logic [N-1:0] rel_i,
    input logic [N-1:0] gnt_o
);

    logic armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    function automatic logic [N-1:0] top_of(input logic [N-1:0] r);
        logic [N-1:0] w;
        w = '0;
        for (int s = N - 1; s >= 0; s--) begin
            if (r[ORDER[s*IW +: IW]]) begin
                w = '0;
                w[ORDER[s*IW +: IW]] = 1'b1;
            end
        end
        return w;
    endfunction

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)); // R4

    AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && (gnt_o & rel_i) == '0) |=> (gnt_o == $past(gnt_o))); // R5

    AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & rel_i) != '0) |=> (gnt_o == '0)); // R7

    AST_NEW_GRANT_RANK: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (gnt_o & ~$past(gnt_o)) != '0) |-> (gnt_o == top_of($past(req_i, 2)))); // R3

    AST_IDLE_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && gnt_o == '0 && $past(req_i) != '0) |=> (gnt_o != '0)); // R8

endmodule

bind busarb_central busarb_central_chk #(.N(N), .IW(IW), .ORDER(ORDER)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .rel_i (rel_i),
    .gnt_o (gnt_o)
);

// File: tb/busarb_central_test.sv
`timescale 1ns/1ps
module busarb_central_test;

    localparam logic [2:0] MA = 3'b001;
    localparam logic [2:0] MB = 3'b010;
    localparam logic [2:0] MC = 3'b100;
    localparam logic [2:0] NONE = 3'b000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_i = '0;
    logic [2:0] rel_i = '0;
    logic [2:0] gnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    busarb_central uut (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i),
        .rel_i (rel_i),
        .gnt_o (gnt_o)
    );

    task automatic chk(input logic [2:0] exp, input string tag);
        checks++;
        if (gnt_o !== exp) begin
            errors++;
            $display("FAIL %s gnt_o actual=%b expected=%b", tag, gnt_o, exp);
        end
    endtask

    // set inputs at a falling edge, wait through one rising edge
    task automatic cyc(input logic [2:0] r, input logic [2:0] l);
        req_i = r;
        rel_i = l;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk(NONE, "R1 in reset");
        rst_n = 1'b1;
        cyc(NONE, NONE);
        chk(NONE, "R1 after reset");
    endtask

    task automatic t_single;
        cyc(MB, NONE);   chk(NONE, "R2 not after first edge");
        cyc(NONE, NONE); chk(MB,   "R2 after second edge");
        cyc(NONE, NONE); chk(MB,   "R6 held without request");
        cyc(NONE, NONE); chk(MB,   "R6 still held");
        cyc(NONE, MB);   chk(NONE, "R7 release clears");
        cyc(NONE, NONE); chk(NONE, "R7 stays idle");
    endtask

    task automatic t_priority;
        cyc(MA | MB | MC, NONE); chk(NONE, "R2 all request");
        cyc(MA | MB | MC, NONE); chk(MA,   "R3 A first");
        cyc(MB | MC, MA);        chk(NONE, "R7 A released");
        cyc(MB | MC, NONE);      chk(MC,   "R3 R8 C next");
        cyc(MB, MC);             chk(NONE, "R7 C released");
        cyc(MB, NONE);           chk(MB,   "R8 B last");
        cyc(NONE, MB);           chk(NONE, "R7 B released");
        cyc(NONE, NONE);         chk(NONE, "R8 nothing left");
    endtask

    task automatic t_preempt;
        cyc(MB, NONE);
        cyc(NONE, NONE);    chk(MB,   "R2 B alone");
        cyc(MA | MC, NONE); chk(MB,   "R5 A and C wait");
        cyc(MA | MC, NONE); chk(MB,   "R5 still B");
        cyc(MA | MC, NONE); chk(MB,   "R5 no preemption");
        cyc(MA | MC, MB);   chk(NONE, "R7 B released");
        cyc(NONE, NONE);    chk(MA,   "R8 R3 A after B");
        cyc(NONE, MA);      chk(NONE, "R7 A released");
        cyc(NONE, NONE);    chk(NONE, "R7 idle");
    endtask

    task automatic t_foreign;
        cyc(MB, NONE);
        cyc(NONE, NONE);    chk(MB,   "R2 B owner");
        cyc(NONE, MA | MC); chk(MB,   "R9 foreign release ignored");
        cyc(NONE, NONE);    chk(MB,   "R9 owner kept");
        cyc(NONE, MB);      chk(NONE, "R7 owner release");
        cyc(NONE, NONE);    chk(NONE, "R9 no stray grant");
    endtask

    task automatic t_regrant;
        cyc(MA, NONE);
        cyc(MA, NONE);   chk(MA,   "R2 A owner");
        cyc(MA, MA);     chk(NONE, "R7 A released");
        cyc(NONE, NONE); chk(MA,   "R8 A regranted");
        cyc(NONE, MA);   chk(NONE, "R7 A released again");
        cyc(NONE, NONE); chk(NONE, "R8 idle");
    endtask

    task automatic t_c_over_b;
        cyc(MB | MC, NONE);
        cyc(NONE, NONE); chk(MC,   "R3 C beats B");
        cyc(NONE, MC);   chk(NONE, "R7 C released");
        cyc(NONE, NONE); chk(NONE, "R3 B request gone");
    endtask

    task automatic t_reset_live;
        cyc(MA, NONE);
        cyc(NONE, NONE); chk(MA, "R2 A before reset");
        rst_n = 1'b0;
        cyc(NONE, NONE); chk(NONE, "R1 reset drops grant");
        rst_n = 1'b1;
        cyc(NONE, NONE); chk(NONE, "R1 idle after reset");
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_preempt();
        t_foreign();
        t_regrant();
        t_c_over_b();
        t_reset_live();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #80000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule